// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of trace words into an on-chip RAM that is used as a ring. Capture is switched on through a control word. Each accepted word is written at the write pointer, and the pointer then advances and wraps modulo the RAM depth. When the pointer wraps, a sticky full flag records that the oldest entries have been overwritten. A trigger input arms a post-trigger countdown. Once that many further entries have been stored, the block declares acquisition complete and ignores all later input.

A host reaches the block through a 32-bit, word-addressed register bus. Through it the host reads the identification, geometry, status and pointers, loads the pointers, the trigger counter and the control word, and empties the buffer through a data register. Each read of the data register returns the entry at the read pointer and then steps that pointer. An optional packed mode joins two consecutive half-width trace words into one RAM entry. A status bit shows whether a half word is still waiting for its partner.

Top module: `trace_ring_buffer`

## Requirements
- R1: A read strobe on `bus_rd` returns data on `bus_rdata` one clock later. Address 0 returns the parameter ID_VALUE, address 1 returns DEPTH, address 2 returns RAM_W (32), and unmapped addresses return 0.
- R2: After reset the read pointer, write pointer, trigger counter and control word are 0. Status (address 3) reads 8, meaning only the formatter-empty bit is set, and capture is off.
- R3: The status word has full at bit 0, triggered at bit 1, acquisition complete at bit 2 and formatter empty at bit 3. Acquisition complete is never set unless triggered is set.
- R4: While control bit 0 is 1, each accepted entry is written at the write pointer (address 6). The write pointer then advances by one, wrapping from DEPTH-1 to 0.
- R5: Full sets when an entry is written at location DEPTH-1. It stays set until capture is restarted.
- R6: A high `trc_trigger` while capturing sets triggered. Every entry stored after the trigger cycle decrements the trigger counter (address 7). The entry stored in the trigger cycle does not count. When triggered is set and the counter is 0, acquisition complete sets and nothing further is stored.
- R7: A read of address 4 returns the RAM entry at the read pointer (address 5) and advances the read pointer by one modulo DEPTH. Writes to addresses 5, 6 and 7 load the read pointer, the write pointer and the trigger counter.
- R8: Writing the control word (address 8) with bit 0 = 0 stops capture and leaves the status flags unchanged. Writing it with bit 0 = 1 clears full, triggered and acquisition complete, drops any pending half word, and restarts capture.
- R9: Trace words that arrive while capture is off, or after acquisition complete, change neither the RAM nor the write pointer.
- R10: With control bit 1 set (packed mode), two consecutive trace words form one entry. The first word goes in bits 15:0 and the second in bits 31:16.
- R11: Formatter empty is low exactly while a first half word waits for its partner. Reaching acquisition complete discards the waiting half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_valid | input | 1 | Trace word present this cycle |
| trc_data | input | RAM_W/2 | Trace word |
| trc_trigger | input | 1 | Trigger event |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after the strobe |

## Verification
A trace word or register write driven before a clock edge is visible to any register read issued after that edge. Every read answers on `bus_rdata` exactly one clock after its strobe. The bench queues the expected value when it issues the strobe. A monitor then compares it at the falling edge that follows the next rising edge, which keeps the check clear of the edge where the value changes. The trigger test relies on two counted cycles. The entry written in the trigger cycle is excluded from the countdown, and completion takes effect on the edge after the counter reaches zero. The bench therefore expects an exact number of stored entries and an exact final write pointer.

// File: rtl/trb_pkg.sv
package trb_pkg;

    typedef enum logic [3:0] {
        REG_ID    = 4'd0,
        REG_DEPTH = 4'd1,
        REG_WIDTH = 4'd2,
        REG_STAT  = 4'd3,
        REG_DATA  = 4'd4,
        REG_RPTR  = 4'd5,
        REG_WPTR  = 4'd6,
        REG_TCNT  = 4'd7,
        REG_CTRL  = 4'd8
    } reg_addr_e;

    // bit 0 full, bit 1 triggered, bit 2 acquisition done, bit 3 formatter empty
    typedef struct packed {
        logic fmt_empty;
        logic acq_done;
        logic triggered;
        logic full;
    } status_t;

    // bit 0 capture enable, bit 1 packed mode
    typedef struct packed {
        logic packed_mode;
        logic enable;
    } ctrl_t;

    function automatic logic [31:0] status_word(status_t s);
        return {28'd0, s};
    endfunction

endpackage

// File: rtl/trb_ram.sv
module trb_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/trb_formatter.sv
module trb_formatter #(
    parameter int IN_W = 16,
    localparam int OUT_W = 2 * IN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             accept,
    input  logic             packed_mode,
    input  logic             flush,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             pending
);
    logic            pend_q;
    logic [IN_W-1:0] half_q;

    always_comb begin
        out_valid = accept && in_valid && (!packed_mode || pend_q);
        out_data  = packed_mode ? {in_data, half_q} : OUT_W'(in_data);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend_q <= 1'b0;
            half_q <= '0;
        end else if (accept && in_valid && packed_mode) begin
            pend_q <= !pend_q;
            if (!pend_q) half_q <= in_data;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/trb_seq.sv
module trb_seq
    import trb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_rptr,
    input  logic             wr_wptr,
    input  logic             wr_tcnt,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    input  logic             data_rd,
    input  logic             trig_in,
    input  logic             entry_wr,
    output ctrl_t            ctrl,
    output logic             accept,
    output logic             flush,
    output logic             restart,
    output logic [PW-1:0]    wptr,
    output logic [PW-1:0]    rptr,
    output logic [CNT_W-1:0] tcnt,
    output logic             full,
    output logic             triggered,
    output logic             done
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic stop_hit;

    always_comb begin
        restart  = wr_ctrl && wdata[0];
        stop_hit = ctrl.enable && !done && triggered && (tcnt == '0);
        accept   = ctrl.enable && !done && !(triggered && (tcnt == '0));
        flush    = stop_hit || restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            wptr      <= '0;
            rptr      <= '0;
            tcnt      <= '0;
            full      <= 1'b0;
            triggered <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata[1:0]);

            if (wr_wptr)       wptr <= wdata[PW-1:0];
            else if (entry_wr) wptr <= (wptr == LAST) ? '0 : wptr + PW'(1);

            if (wr_rptr)      rptr <= wdata[PW-1:0];
            else if (data_rd) rptr <= (rptr == LAST) ? '0 : rptr + PW'(1);

            if (wr_tcnt) tcnt <= wdata;
            else if (entry_wr && triggered && tcnt != '0) tcnt <= tcnt - CNT_W'(1);

            if (entry_wr && wptr == LAST) full <= 1'b1;
            if (ctrl.enable && !done && trig_in) triggered <= 1'b1;
            if (stop_hit) done <= 1'b1;

            if (restart) begin
                full      <= 1'b0;
                triggered <= 1'b0;
                done      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer
    import trb_pkg::*;
#(
    parameter int          DEPTH    = 64,
    parameter int          RAM_W    = 32,
    parameter int          CNT_W    = 16,
    parameter logic [31:0] ID_VALUE = 32'h7B10_0001,
    localparam int         IN_W     = RAM_W / 2,
    localparam int         PW       = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trc_valid,
    input  logic [IN_W-1:0] trc_data,
    input  logic            trc_trigger,
    input  logic [3:0]      bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata
);
    reg_addr_e  sel;
    logic       wr_rptr, wr_wptr, wr_tcnt, wr_ctrl, data_rd;
    ctrl_t      ctrl;
    logic       accept, flush, restart, full, triggered, done, pending;
    logic       ram_we;
    logic [RAM_W-1:0] ram_wdata, ram_rdata;
    logic [PW-1:0]    wptr, rptr;
    logic [CNT_W-1:0] tcnt;
    status_t    stat;
    logic [31:0] rdata_q;
    logic        from_ram_q;
    logic        unused_wdata;

    assign unused_wdata = ^bus_wdata[31:CNT_W];

    always_comb begin
        sel     = reg_addr_e'(bus_addr);
        wr_rptr = bus_wr && sel == REG_RPTR;
        wr_wptr = bus_wr && sel == REG_WPTR;
        wr_tcnt = bus_wr && sel == REG_TCNT;
        wr_ctrl = bus_wr && sel == REG_CTRL;
        data_rd = bus_rd && sel == REG_DATA;
        stat    = '{fmt_empty: !pending, acq_done: done, triggered: triggered, full: full};
    end

    trb_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst(rst),
        .wr_rptr(wr_rptr), .wr_wptr(wr_wptr), .wr_tcnt(wr_tcnt), .wr_ctrl(wr_ctrl),
        .wdata(bus_wdata[CNT_W-1:0]), .data_rd(data_rd), .trig_in(trc_trigger),
        .entry_wr(ram_we), .ctrl(ctrl), .accept(accept), .flush(flush),
        .restart(restart), .wptr(wptr), .rptr(rptr), .tcnt(tcnt),
        .full(full), .triggered(triggered), .done(done)
    );

    trb_formatter #(.IN_W(IN_W)) fmt_i (
        .clk(clk), .rst(rst), .in_valid(trc_valid), .in_data(trc_data),
        .accept(accept), .packed_mode(ctrl.packed_mode), .flush(flush),
        .out_valid(ram_we), .out_data(ram_wdata), .pending(pending)
    );

    trb_ram #(.DEPTH(DEPTH), .W(RAM_W)) ram_i (
        .clk(clk), .rst(rst), .wr_en(ram_we), .wr_addr(wptr), .wr_data(ram_wdata),
        .rd_en(data_rd), .rd_addr(rptr), .rd_data(ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q    <= '0;
            from_ram_q <= 1'b0;
        end else begin
            from_ram_q <= data_rd;
            if (bus_rd) begin
                case (sel)
                    REG_ID:    rdata_q <= ID_VALUE;
                    REG_DEPTH: rdata_q <= 32'(DEPTH);
                    REG_WIDTH: rdata_q <= 32'(RAM_W);
                    REG_STAT:  rdata_q <= status_word(stat);
                    REG_RPTR:  rdata_q <= 32'(rptr);
                    REG_WPTR:  rdata_q <= 32'(wptr);
                    REG_TCNT:  rdata_q <= 32'(tcnt);
                    REG_CTRL:  rdata_q <= 32'(ctrl);
                    default:   rdata_q <= '0;
                endcase
            end
        end
    end

    assign bus_rdata = from_ram_q ? 32'(ram_rdata) : rdata_q;
endmodule

// File: rtl/trb_checker.sv
module trb_checker #(
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          full,
    input logic          triggered,
    input logic          done,
    input logic          ram_we,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic          restart,
    input logic          wr_wptr,
    input logic          wr_rptr,
    input logic          data_rd
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    // R3
    done_needs_trig_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> triggered);

    // R9
    no_store_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !ram_we);

    // R4
    wptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ram_we) && !$past(wr_wptr)) |->
            (($past(wptr) == LAST) ? (wptr == '0) : (wptr == $past(wptr) + PW'(1))));

    // R7
    rptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(data_rd) && !$past(wr_rptr)) |->
            (($past(rptr) == LAST) ? (rptr == '0) : (rptr == $past(rptr) + PW'(1))));

    // R5
    full_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(full) |-> $past(restart));

    // R8
    trig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(triggered) |-> $past(restart));
endmodule

bind trace_ring_buffer trb_checker #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .full(full), .triggered(triggered), .done(done),
    .ram_we(ram_we), .wptr(wptr), .rptr(rptr), .restart(restart),
    .wr_wptr(wr_wptr), .wr_rptr(wr_rptr), .data_rd(data_rd)
);

// File: tb/trace_ring_buffer_tb_top.sv
module trace_ring_buffer_tb_top;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trc_valid = 1'b0;
    logic [15:0] trc_data = '0;
    logic        trc_trigger = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    logic pend_rd = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    trace_ring_buffer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .trc_valid(trc_valid), .trc_data(trc_data),
        .trc_trigger(trc_trigger), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // monitor: a read strobe seen at a rising edge answers at the next falling edge
    always @(posedge clk) pend_rd <= bus_rd && !rst;

    always @(negedge clk) begin
        if (pend_rd) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: unexpected read result act=%h exp=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: act=%h exp=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [15:0] d, input logic trg);
        @(negedge clk);
        trc_valid = 1'b1; trc_data = d; trc_trigger = trg;
        @(negedge clk);
        trc_valid = 1'b0; trc_trigger = 1'b0;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 identification and geometry
        bus_read(4'd0, 32'h7B10_0001, "R1 id");
        bus_read(4'd1, 32'(DEPTH), "R1 depth");
        bus_read(4'd2, 32'd32, "R1 width");
        bus_read(4'd12, 32'd0, "R1 unmapped");
        // R2 reset state
        bus_read(4'd3, 32'd8, "R2 status");
        bus_read(4'd6, 32'd0, "R2 wptr");
        bus_read(4'd5, 32'd0, "R2 rptr");
        bus_read(4'd8, 32'd0, "R2 ctrl");

        // R4 plain capture of five words
        bus_write(4'd8, 32'd1);
        for (int i = 0; i < 5; i++) push(16'h1000 + 16'(i), 1'b0);
        bus_write(4'd8, 32'd0);
        bus_read(4'd6, 32'd5, "R4 wptr after 5");
        bus_read(4'd3, 32'd8, "R5 not full");
        // R7 drain with auto increment
        bus_write(4'd5, 32'd0);
        for (int i = 0; i < 5; i++) bus_read(4'd4, 32'h1000 + 32'(i), "R7 drain");
        bus_read(4'd5, 32'd5, "R7 rptr advanced");

        // R9 ignored while disabled
        for (int i = 0; i < 3; i++) push(16'hDEAD, 1'b0);
        bus_read(4'd6, 32'd5, "R9 wptr unchanged when off");

        // R5 wrap and full
        bus_write(4'd6, 32'd60);
        bus_write(4'd8, 32'd1);
        for (int i = 0; i < 6; i++) push(16'h2000 + 16'(i), 1'b0);
        bus_write(4'd8, 32'd0);
        bus_read(4'd6, 32'd2, "R4 wptr wrapped");
        bus_read(4'd3, 32'd9, "R5 full set");
        bus_write(4'd5, 32'd60);
        for (int i = 0; i < 6; i++) bus_read(4'd4, 32'h2000 + 32'(i), "R7 wrapped drain");
        bus_read(4'd5, 32'd2, "R7 rptr wrapped");

        // R6 post-trigger countdown of three entries
        bus_write(4'd7, 32'd3);
        bus_write(4'd6, 32'd0);
        bus_write(4'd8, 32'd1);
        bus_read(4'd3, 32'd8, "R8 restart clears full");
        push(16'h3000, 1'b0);
        push(16'h3001, 1'b0);
        push(16'h3002, 1'b1);
        for (int i = 3; i < 8; i++) push(16'h3000 + 16'(i), 1'b0);
        bus_read(4'd6, 32'd6, "R6 stored count");
        bus_read(4'd3, 32'd14, "R6 status trig+done");
        bus_read(4'd7, 32'd0, "R6 counter exhausted");
        bus_write(4'd5, 32'd5);
        bus_read(4'd4, 32'h3005, "R6 last entry");
        // R9 dropped after completion
        push(16'hBEEF, 1'b0);
        bus_read(4'd6, 32'd6, "R9 wptr unchanged after done");

        // R8 stop keeps flags, restart clears
        bus_write(4'd8, 32'd0);
        bus_read(4'd3, 32'd14, "R8 stop keeps flags");
        bus_write(4'd8, 32'd1);
        bus_read(4'd3, 32'd8, "R8 restart clears flags");

        // R10 packed mode, R11 formatter empty
        bus_write(4'd8, 32'd0);
        bus_write(4'd7, 32'd0);
        bus_write(4'd6, 32'd0);
        bus_write(4'd8, 32'd3);
        push(16'hAAAA, 1'b0);
        push(16'h5555, 1'b0);
        push(16'h1234, 1'b0);
        bus_read(4'd3, 32'd0, "R11 half pending");
        push(16'h9999, 1'b0);
        bus_read(4'd3, 32'd8, "R11 pair completed");
        bus_read(4'd6, 32'd2, "R10 two packed entries");
        push(16'h4444, 1'b1);
        bus_read(4'd3, 32'd14, "R11 pending discarded at done");
        bus_read(4'd6, 32'd2, "R11 no extra entry");
        bus_write(4'd5, 32'd0);
        bus_read(4'd4, 32'h5555_AAAA, "R10 first packed entry");
        bus_read(4'd4, 32'h9999_1234, "R10 second packed entry");

        finish_run();
    end
endmodule